// File: doc/BRIEF.md
# Frame-Clock Lock Guard

This block sits between the serial audio front end and the sample datapath of a converter. Both the bit clock and the frame (left/right) clock arrive without a known relation to the master clock. Each one passes through a two-flop synchronizer into the master domain, and its rising edges are detected there. The block keeps a running count of bit-clock edges. At every frame edge it stores that count. It compares the stored value with the one from the previous frame, and the difference is the frame's phase movement, counted in bit clocks. The frame clock may sit at any fixed phase. Only movement from one frame to the next counts against it.

A frame whose phase moves by six bit clocks or more drops lock. The playback and capture sample words are then replaced by the two's complement zero code from that frame boundary onward. Lock returns after two frames in a row that each move by five bit clocks or less. After that, the playback path waits a fixed number of frames before passing data again, and the capture path waits longer. After reset is released, both paths stay at zero for a long fixed number of frames. All output words change only on frame boundaries.

Top module: `frame_lock_guard`

## Requirements
- R1: Right after reset is released, `play_out` and `cap_out` are all zeros and `locked` is 1. Both outputs stay at zero for the first RST_HOLD frame ticks (default 4096). Data first appears at tick number RST_HOLD.
- R2: A frame clock at any fixed offset from the bit clock, including offsets smaller than one bit period, keeps `locked` at 1.
- R3: A frame whose phase change is 5 bit clocks or fewer (OK_BITS) leaves `locked` at 1 and data passing.
- R4: A frame whose phase change is 6 bit clocks or more (LOSS_BITS) clears `locked` at that frame tick. Both outputs become zero at that same tick.
- R5: The phase change is the wraparound distance between the bit counts latched on consecutive frame edges, taken modulo BITS_PER_FRAME. A shift of k bits counts as min(k, BITS_PER_FRAME - k).
- R6: Lock returns on the second of two consecutive ticks that each show a change of OK_BITS or fewer. A tick with a larger change restarts that count.
- R7: Counted from the tick that restores lock, `play_out` carries data again PLAY_RECOV ticks later (default 22) and `cap_out` carries data again CAP_RECOV ticks later (default 32).
- R8: The outputs change only at a frame tick. A frame tick is registered 3 master clock cycles after the frame clock rises. Input words that change between ticks never reach the outputs.
- R9: When a path is not muted, its output equals the input word sampled at the frame tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bclk_in | input | 1 | Bit clock, asynchronous to clk |
| fclk_in | input | 1 | Frame clock, asynchronous to clk |
| play_in | input | SAMPLE_W | Playback sample word |
| cap_in | input | SAMPLE_W | Capture sample word |
| play_out | output | SAMPLE_W | Gated playback word |
| cap_out | output | SAMPLE_W | Gated capture word |
| locked | output | 1 | 1 while the frame clock is judged locked |

## Verification
The bench moves the frame clock by exactly five bits and by exactly six bits. A threshold that is off by one would keep lock on the six-bit move or drop it on the five-bit move. It also applies shifts of ten and twelve bits. A design that subtracted without wrapping would read these as large moves, when they are really six and four. Between two good frames it inserts a seven-bit move, which catches a relock counter that fails to restart. It lets the recovery run fully and checks that playback and capture come back on separate ticks, which exposes swapped or shared timers. It also changes the input words in the middle of every frame, so a design that passes data outside the frame boundary shows torn words.

// File: rtl/flg_pkg.sv
// Shared helpers for the frame-clock lock guard.
// Assumes: used only in constant (elaboration-time) expressions.
package flg_pkg;

    // Largest of three counts, used to size the recovery timers.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/edge_sync.sv
// Brings one asynchronous clock-like input into the clk domain through two
// flops and flags its rising edge for one cycle.
// Assumes: the input is low while reset is held, and each level lasts at least
// two clk cycles.
module edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic meta_q, sync_q, last_q;

    // Two-flop synchronizer followed by a history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    // Rising edge seen in the synchronized level.
    assign rise = sync_q & ~last_q;
endmodule

// File: rtl/phase_tracker.sv
// Counts bit-clock edges modulo the frame length. At each frame tick it
// compares the count with the one latched at the previous tick and reports
// the wraparound distance in bit clocks.
// Assumes: BITS_PER_FRAME is a power of two, so the counter wraps naturally.
module phase_tracker #(
    parameter int BITS_PER_FRAME = 64,
    localparam int CW = $clog2(BITS_PER_FRAME)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_rise,
    input  logic          frame_tick,
    output logic          drift_valid,
    output logic [CW-1:0] drift
);
    localparam logic [CW:0] HALF = (CW+1)'(BITS_PER_FRAME / 2);

    logic [CW-1:0] bit_cnt, prev_cnt, diff;
    logic          have_prev;

    // Free-running bit-clock counter in the master domain.
    always_ff @(posedge clk) begin
        if (!rst_n)        bit_cnt <= '0;
        else if (bit_rise) bit_cnt <= bit_cnt + 1'b1;
    end

    // Latch the count of the current frame for comparison at the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_cnt  <= '0;
            have_prev <= 1'b0;
        end else if (frame_tick) begin
            prev_cnt  <= bit_cnt;
            have_prev <= 1'b1;
        end
    end

    // Shortest distance around the frame circle between the two counts.
    always_comb begin
        diff  = bit_cnt - prev_cnt;
        drift = ({1'b0, diff} > HALF) ? (~diff + 1'b1) : diff;
    end

    assign drift_valid = frame_tick & have_prev;

    // R5: a wraparound distance never exceeds half a frame.
    a_r5_drift_within_half: assert property (@(posedge clk) disable iff (!rst_n)
        drift_valid |-> ({1'b0, drift} <= HALF));
endmodule

// File: rtl/lock_ctrl.sv
// Lock decision. A large phase step drops lock. Two good frames in a row
// restore it and raise a one-cycle relock pulse.
// Assumes: drift_valid is only high on a frame tick.
module lock_ctrl #(
    parameter int CW        = 6,
    parameter int LOSS_BITS = 6,
    parameter int OK_BITS   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          drift_valid,
    input  logic [CW-1:0] drift,
    output logic          locked,
    output logic          locked_nxt,
    output logic          relock
);
    localparam logic [CW-1:0] LOSS_T = CW'(LOSS_BITS);
    localparam logic [CW-1:0] OK_T   = CW'(OK_BITS);

    logic one_good, one_good_nxt;

    // Next lock state from the phase step measured on this tick.
    always_comb begin
        locked_nxt   = locked;
        one_good_nxt = one_good;
        relock       = 1'b0;
        if (drift_valid) begin
            if (locked) begin
                if (drift >= LOSS_T) begin
                    locked_nxt   = 1'b0;
                    one_good_nxt = 1'b0;
                end
            end else if (drift <= OK_T) begin
                if (one_good) begin
                    locked_nxt   = 1'b1;
                    relock       = 1'b1;
                    one_good_nxt = 1'b0;
                end else begin
                    one_good_nxt = 1'b1;
                end
            end else begin
                one_good_nxt = 1'b0;
            end
        end
    end

    // Lock state registers; the block starts out locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked   <= 1'b1;
            one_good <= 1'b0;
        end else begin
            locked   <= locked_nxt;
            one_good <= one_good_nxt;
        end
    end

    // R4: a large step while locked drops lock.
    a_r4_step_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (drift_valid && locked && drift >= LOSS_T) |=> !locked);
    // R6: a single good frame is not enough to relock.
    a_r6_single_frame_no_relock: assert property (@(posedge clk) disable iff (!rst_n)
        (drift_valid && !locked && !one_good) |=> !locked);
    // R6: a bad frame while unlocked restarts the good-frame count.
    a_r6_bad_frame_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (drift_valid && !locked && drift > OK_T) |=> (!locked && !one_good));
endmodule

// File: rtl/recover_timer.sv
// Frame-count mute timer for one output path. It is loaded with HOLD_FR at
// reset and with RECOV_FR on relock, counts down on locked frame ticks, and
// reports whether the path must be muted at the current tick.
// Assumes: relock is only high on a frame tick.
module recover_timer #(
    parameter int HOLD_FR  = 4096,
    parameter int RECOV_FR = 22,
    parameter int WW       = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_tick,
    input  logic locked_nxt,
    input  logic relock,
    output logic mute_nxt
);
    localparam logic [WW-1:0] HOLD_T  = WW'(HOLD_FR);
    localparam logic [WW-1:0] RECOV_T = WW'(RECOV_FR);

    logic [WW-1:0] remain, remain_nxt;

    // Reload on relock, otherwise count down one per locked frame.
    always_comb begin
        remain_nxt = remain;
        if (frame_tick) begin
            if (relock)                          remain_nxt = RECOV_T;
            else if (locked_nxt && remain != '0) remain_nxt = remain - 1'b1;
        end
        mute_nxt = !locked_nxt || (remain_nxt != '0);
    end

    // Frames left before this path may carry data again.
    always_ff @(posedge clk) begin
        if (!rst_n) remain <= HOLD_T;
        else        remain <= remain_nxt;
    end

    // R7: right after a relock the path is still waiting.
    a_r7_wait_after_relock: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && relock) |=> (remain != '0));
endmodule

// File: rtl/frame_lock_guard.sv
// Top level. It synchronizes the bit and frame clocks, tracks the frame phase,
// decides lock, and gates the playback and capture words to zero on frame
// boundaries while lock is missing or a recovery wait is running.
// Assumes: clk is several times faster than the bit clock; BITS_PER_FRAME is a
// power of two.
module frame_lock_guard #(
    parameter int SAMPLE_W       = 24,
    parameter int BITS_PER_FRAME = 64,
    parameter int LOSS_BITS      = 6,
    parameter int OK_BITS        = 5,
    parameter int PLAY_RECOV     = 22,
    parameter int CAP_RECOV      = 32,
    parameter int RST_HOLD       = 4096
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_in,
    input  logic                fclk_in,
    input  logic [SAMPLE_W-1:0] play_in,
    input  logic [SAMPLE_W-1:0] cap_in,
    output logic [SAMPLE_W-1:0] play_out,
    output logic [SAMPLE_W-1:0] cap_out,
    output logic                locked
);
    localparam int CW = $clog2(BITS_PER_FRAME);
    localparam int WW = $clog2(flg_pkg::max3(RST_HOLD, PLAY_RECOV, CAP_RECOV) + 1);

    logic          bit_rise, frame_tick, drift_valid, locked_nxt, relock;
    logic          play_mute, cap_mute;
    logic [CW-1:0] drift;

    edge_sync u_bclk_sync (.clk(clk), .rst_n(rst_n), .async_in(bclk_in), .rise(bit_rise));
    edge_sync u_fclk_sync (.clk(clk), .rst_n(rst_n), .async_in(fclk_in), .rise(frame_tick));

    phase_tracker #(.BITS_PER_FRAME(BITS_PER_FRAME)) u_phase (
        .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .frame_tick(frame_tick),
        .drift_valid(drift_valid), .drift(drift)
    );

    lock_ctrl #(.CW(CW), .LOSS_BITS(LOSS_BITS), .OK_BITS(OK_BITS)) u_lock (
        .clk(clk), .rst_n(rst_n), .drift_valid(drift_valid), .drift(drift),
        .locked(locked), .locked_nxt(locked_nxt), .relock(relock)
    );

    recover_timer #(.HOLD_FR(RST_HOLD), .RECOV_FR(PLAY_RECOV), .WW(WW)) u_play_tmr (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .locked_nxt(locked_nxt),
        .relock(relock), .mute_nxt(play_mute)
    );

    recover_timer #(.HOLD_FR(RST_HOLD), .RECOV_FR(CAP_RECOV), .WW(WW)) u_cap_tmr (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .locked_nxt(locked_nxt),
        .relock(relock), .mute_nxt(cap_mute)
    );

    // Update both output words only on a frame boundary, zero when muted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            play_out <= '0;
            cap_out  <= '0;
        end else if (frame_tick) begin
            play_out <= play_mute ? '0 : play_in;
            cap_out  <= cap_mute  ? '0 : cap_in;
        end
    end

    // R4: without lock both paths carry the zero code.
    a_r4_zero_while_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (play_out == '0 && cap_out == '0));
    // R8: outside a frame tick the outputs hold their words.
    a_r8_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> ($stable(play_out) && $stable(cap_out)));
endmodule

// File: tb/frame_lock_guard_tb.sv
// Self-checking bench with a behavioural per-frame reference model. The
// expected words are queued with the cycle in which they must appear and are
// compared on every clock.
module frame_lock_guard_tb;
    localparam int W  = 24;
    localparam int N  = 16;
    localparam int RH = 40;
    localparam int PR = 22;
    localparam int CR = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bclk_in = 1'b0;
    logic         fclk_in = 1'b0;
    logic [W-1:0] play_in = '0;
    logic [W-1:0] cap_in = '0;
    logic [W-1:0] play_out, cap_out;
    logic         locked;

    always #10 clk = ~clk;

    frame_lock_guard #(.SAMPLE_W(W), .BITS_PER_FRAME(N), .RST_HOLD(RH)) u_dut (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .fclk_in(fclk_in),
        .play_in(play_in), .cap_in(cap_in),
        .play_out(play_out), .cap_out(cap_out), .locked(locked)
    );

    typedef struct {
        int           at;
        logic [W-1:0] p;
        logic [W-1:0] c;
        logic         l;
    } upd_t;

    upd_t         pend[$];
    int           cyc = 0, checks = 0, fails = 0;
    logic [W-1:0] e_play = '0, e_cap = '0;
    logic         e_lock = 1'b1;
    bit           chk_on = 1'b0;
    string        req = "R1";

    // Reference model state
    int bph = 0, bcnt = 0, prev = 0, have_prev = 0;
    int m_lock = 1, m_good = 0, m_pw = RH, m_cw = RH;

    // Compare every cycle, away from the clock edge
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #2;
            while (pend.size() > 0 && pend[0].at <= cyc) begin
                e_play = pend[0].p;
                e_cap  = pend[0].c;
                e_lock = pend[0].l;
                void'(pend.pop_front());
            end
            if (chk_on) begin
                checks++;
                // R8/R9: the words and the flag match the model on every cycle
                if (play_out !== e_play || cap_out !== e_cap || locked !== e_lock) begin
                    fails++;
                    $display("FAIL %s cyc %0d: play=%h exp %h cap=%h exp %h locked=%b exp %b",
                             req, cyc, play_out, e_play, cap_out, e_cap, locked, e_lock);
                end
            end
        end
    end

    // Behavioural model of one frame tick
    task automatic model_frame();
        int d, dr, relock;
        play_in = W'($urandom);
        cap_in  = W'($urandom);
        relock  = 0;
        if (have_prev != 0) begin
            d  = (bcnt - prev + N) % N;
            dr = (d > N / 2) ? N - d : d;
            if (m_lock != 0) begin
                if (dr >= 6) begin m_lock = 0; m_good = 0; end
            end else if (dr <= 5) begin
                if (m_good != 0) begin m_lock = 1; m_good = 0; relock = 1; end
                else m_good = 1;
            end else begin
                m_good = 0;
            end
        end
        prev = bcnt;
        have_prev = 1;
        if (relock != 0) begin
            m_pw = PR;
            m_cw = CR;
        end else if (m_lock != 0) begin
            if (m_pw > 0) m_pw--;
            if (m_cw > 0) m_cw--;
        end
        pend.push_back('{cyc + 3,
                         (m_lock == 0 || m_pw != 0) ? '0 : play_in,
                         (m_lock == 0 || m_cw != 0) ? '0 : cap_in,
                         m_lock[0]});
    endtask

    // One master cycle of stimulus: frame level, bit clock with period 4
    task automatic drive(input bit f);
        @(negedge clk);
        if (f && !fclk_in) begin
            fclk_in = 1'b1;
            model_frame();
        end else if (!f && fclk_in) begin
            fclk_in = 1'b0;
            play_in = W'($urandom);   // R8: mid-frame change must not show
            cap_in  = W'($urandom);
        end
        bph++;
        if (bph % 4 == 2) begin
            bclk_in = 1'b1;
            bcnt = (bcnt + 1) % N;
        end else if (bph % 4 == 0) begin
            bclk_in = 1'b0;
        end
    endtask

    // One frame, stretched by extra master cycles (4 cycles per bit)
    task automatic run_frame(input int extra);
        for (int i = 0; i < N * 4 + extra; i++) drive(i < N * 2);
    endtask

    task automatic run_frames(input int n);
        for (int k = 0; k < n; k++) run_frame(0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, exp completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1'b1;
        // R1: reset state, zero words and locked flag
        @(posedge clk);
        #3;
        checks++;
        if (play_out !== '0 || cap_out !== '0 || locked !== 1'b1) begin
            fails++;
            $display("FAIL R1 reset: play=%h cap=%h locked=%b exp 0 0 1", play_out, cap_out, locked);
        end
        // R2: arbitrary starting offset, not a whole bit
        for (int i = 0; i < 7; i++) drive(1'b0);
        req = "R1";  run_frames(RH + 1);
        req = "R9";  run_frames(3);
        req = "R2";  run_frame(3); run_frame(1); run_frame(2); run_frames(2);
        req = "R3";  run_frame(5 * 4); run_frames(3);
        req = "R5";  run_frame(12 * 4); run_frames(3);
        req = "R4";  run_frame(6 * 4); run_frames(1);
        req = "R6";  run_frame(7 * 4); run_frames(3);
        req = "R7";  run_frames(CR + 2);
        req = "R5";  run_frame(10 * 4); run_frames(3);
        req = "R7";  run_frames(CR + 2);
        req = "R8";  run_frames(3);
        repeat (5) @(posedge clk);
        #3;
        // R7: both paths carry data at the end of the run
        checks++;
        if (locked !== 1'b1 || play_out !== e_play || cap_out !== e_cap) begin
            fails++;
            $display("FAIL R7 final: locked=%b exp 1 play=%h exp %h", locked, play_out, e_play);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule